// File: doc/BRIEF.md
# Cartridge bank-switching memory mapper

This block sits between an 8-bit CPU bus, a picture-processor bus and two larger ROMs. CPU writes in the upper 32 KB of CPU space are decoded into bank and mirroring registers. The same registers then steer address translation. The CPU's 8 KB program windows become program-ROM addresses. The picture bus's 1 KB pattern windows become pattern-ROM addresses. A single output bit chooses which page of nametable RAM the picture bus sees.

Each 8-bit pattern-bank number is loaded as two 4-bit halves, written to neighbouring register locations. Each half-write leaves the other half untouched. A strap input selects between two board wirings. In the alternate wiring, CPU address lines A0 and A1 swap places before decode, and every pattern-bank number is halved (shifted right by one) before use.

The top two program windows are wired to the last two ROM banks. Only the lower two windows can be switched. Register writes use the CPU data bus alone.

Top module: `cart_bank_mapper`

## Requirements
- R1: After a synchronous reset, all bank registers are zero and the mirroring mode is vertical (0).
- R2: A register changes only on a rising clock edge where `cpu_wr` and `rom_sel` are both high. If either is low, no register changes.
- R3: A write to CPU page $8xxx loads data bits [3:0] into the bank used for CPU $8000–$9FFF. Data bits [7:4] are ignored. Program-ROM address = {bank, cpu_addr[12:0]}.
- R4: A write to page $Axxx loads data bits [3:0] into the bank used for CPU $A000–$BFFF.
- R5: CPU $C000–$DFFF always maps to program bank 14, and $E000–$FFFF always maps to bank 15 (the last two banks of a 16-bank ROM).
- R6: A write to page $9xxx loads data bits [1:0] as the mirroring mode. The nametable page output is then: mode 0 gives ppu_addr[10], mode 1 gives ppu_addr[11], mode 2 gives constant 0, and mode 3 gives constant 1.
- R7: ppu_addr[12:10] selects pattern bank k (0–7). The pattern-ROM address is {bank_k, ppu_addr[9:0]}. Bank k is written at page $B/$C/$D/$E for k/2 = 0/1/2/3, with the register-select line corresponding to A1 equal to k mod 2.
- R8: In a pattern register pair, select line A0 = 0 writes bank bits [3:0] and A0 = 1 writes bits [7:4], both taken from data bits [3:0]. The other half keeps its value.
- R9: Decode looks only at cpu_addr[15:12] and cpu_addr[1:0]. Every register repeats throughout its 4 KB page.
- R10: With `variant_sel` high, cpu_addr[0] acts as the A1 select and cpu_addr[1] acts as the A0 select. Offsets 1 and 2 trade places.
- R11: With `variant_sel` high, the stored 8-bit pattern value is shifted right by one before use. Pattern-ROM address bit 17 is therefore 0.
- R12: Writes to page $Fxxx change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_sel | input | 1 | Board-wiring strap: swap select lines and halve pattern banks |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| cpu_wr | input | 1 | CPU write strobe, active high |
| rom_sel | input | 1 | ROM-space select, active high |
| ppu_addr | input | 14 | Picture-processor address bus |
| prg_addr | output | 17 | Program-ROM address |
| chr_addr | output | 18 | Pattern-ROM address |
| nt_page | output | 1 | Nametable RAM page bit |

## Verification
The bench builds the block with the default 4-bit program-bank width. This puts the two fixed banks at 14 and 15, and the bench can check them against the register-driven windows over the full 16-bank range. With the full 8-bit pattern width, every half of every pattern register can be set to a distinct value, so a swapped half or a swapped bank index shows up in the output. Running the same writes with the strap in both states covers the exchange of select lines and the halved bank number.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    localparam int NIB_W     = 4;
    localparam int PAT_W     = 2 * NIB_W;
    localparam int NUM_PAT   = 8;
    localparam int PAT_IDX_W = $clog2(NUM_PAT);
    localparam int PRG_OFS_W = 13;
    localparam int PAT_OFS_W = 10;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mir_mode_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PRG_LO,
        TGT_MIRROR,
        TGT_PRG_HI,
        TGT_PAT
    } tgt_e;

    typedef struct packed {
        tgt_e                 tgt;
        logic [PAT_IDX_W-1:0] idx;
        logic                 hi;
    } wr_cmd_t;

    // Effective {A1-role, A0-role} after the board-wiring strap.
    function automatic logic [1:0] reg_sel(input logic variant, input logic [1:0] lo);
        return variant ? {lo[0], lo[1]} : lo;
    endfunction

    function automatic wr_cmd_t decode_cmd(input logic [3:0] page, input logic [1:0] sel);
        wr_cmd_t    c;
        logic [3:0] grp;
        c.tgt = TGT_NONE;
        c.idx = '0;
        c.hi  = 1'b0;
        grp   = page - 4'hB;
        case (page)
            4'h8: c.tgt = TGT_PRG_LO;
            4'h9: c.tgt = TGT_MIRROR;
            4'hA: c.tgt = TGT_PRG_HI;
            4'hB, 4'hC, 4'hD, 4'hE: begin
                c.tgt = TGT_PAT;
                c.idx = {grp[1:0], sel[1]};
                c.hi  = sel[0];
            end
            default: c.tgt = TGT_NONE;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/cbm_reg_file.sv
module cbm_reg_file
    import cbm_pkg::*;
#(
    parameter int PRG_BANK_W = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               variant_sel,
    input  logic [3:0]                         cpu_page,
    input  logic [1:0]                         cpu_lo,
    input  logic [PRG_BANK_W-1:0]              cpu_data,
    input  logic                               cpu_wr,
    input  logic                               rom_sel,
    output logic [PRG_BANK_W-1:0]              prg_lo,
    output logic [PRG_BANK_W-1:0]              prg_hi,
    output mir_mode_e                          mirror,
    output logic [NUM_PAT-1:0][PAT_W-1:0]      pat_raw
);
    logic    wr_en;
    wr_cmd_t cmd;
    logic [1:0] sel_eff;

    assign wr_en   = cpu_wr & rom_sel;
    assign sel_eff = reg_sel(variant_sel, cpu_lo);
    assign cmd     = decode_cmd(cpu_page, sel_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            prg_lo <= '0;
            prg_hi <= '0;
            mirror <= MIR_VERT;
        end else if (wr_en) begin
            case (cmd.tgt)
                TGT_PRG_LO: prg_lo <= cpu_data;
                TGT_PRG_HI: prg_hi <= cpu_data;
                TGT_MIRROR: mirror <= mir_mode_e'(cpu_data[1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_raw <= '0;
        end else if (wr_en && cmd.tgt == TGT_PAT) begin
            for (int k = 0; k < NUM_PAT; k++) begin
                if (cmd.idx == PAT_IDX_W'(k)) begin
                    if (cmd.hi)
                        pat_raw[k][PAT_W-1:NIB_W] <= cpu_data[NIB_W-1:0];
                    else
                        pat_raw[k][NIB_W-1:0] <= cpu_data[NIB_W-1:0];
                end
            end
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && rom_sel) |=> ($stable(prg_lo) && $stable(prg_hi) && $stable(mirror) && $stable(pat_raw))); // R2
    AST_PRG_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && rom_sel && cpu_page == 4'h8) |=> (prg_lo == $past(cpu_data))); // R3
    AST_PRG_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && rom_sel && cpu_page == 4'hA) |=> (prg_hi == $past(cpu_data))); // R4
    AST_TOP_PAGE_INERT: assert property (@(posedge clk) disable iff (rst)
        (cpu_page == 4'hF) |=> ($stable(prg_lo) && $stable(prg_hi) && $stable(mirror) && $stable(pat_raw))); // R12
    AST_NIB_KEEP: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && rom_sel && cpu_page == 4'hB &&
         (variant_sel ? {cpu_lo[0], cpu_lo[1]} : cpu_lo) == 2'b00)
        |=> $stable(pat_raw[0][PAT_W-1:NIB_W])); // R8
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map
    import cbm_pkg::*;
#(
    parameter int PRG_BANK_W = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [14:0]                       cpu_addr,
    input  logic [PRG_BANK_W-1:0]             prg_lo,
    input  logic [PRG_BANK_W-1:0]             prg_hi,
    output logic [PRG_BANK_W+PRG_OFS_W-1:0]   prg_addr
);
    localparam int PRG_AW = PRG_BANK_W + PRG_OFS_W;
    localparam logic [PRG_BANK_W-1:0] BANK_LAST   = '1;
    localparam logic [PRG_BANK_W-1:0] BANK_PENULT = {{(PRG_BANK_W-1){1'b1}}, 1'b0};

    logic [PRG_BANK_W-1:0] bank;

    always_comb begin
        case (cpu_addr[14:13])
            2'b00:   bank = prg_lo;
            2'b01:   bank = prg_hi;
            2'b10:   bank = BANK_PENULT;
            default: bank = BANK_LAST;
        endcase
    end

    assign prg_addr = {bank, cpu_addr[PRG_OFS_W-1:0]};

    AST_FIXED_LAST: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[14:13] == 2'b11) |-> (&prg_addr[PRG_AW-1:PRG_OFS_W])); // R5
    AST_FIXED_PENULT: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[14:13] == 2'b10) |-> (prg_addr[PRG_AW-1:PRG_OFS_W+1] == '1 && !prg_addr[PRG_OFS_W])); // R5
endmodule

// File: rtl/cbm_pat_map.sv
module cbm_pat_map
    import cbm_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           variant_sel,
    input  logic [12:0]                    ppu_addr,
    input  logic [NUM_PAT-1:0][PAT_W-1:0]  pat_raw,
    input  mir_mode_e                      mirror,
    output logic [PAT_W+PAT_OFS_W-1:0]     chr_addr,
    output logic                           nt_page
);
    localparam int CHR_AW = PAT_W + PAT_OFS_W;

    logic [NUM_PAT-1:0][PAT_W-1:0] pat_eff;

    always_comb begin
        for (int k = 0; k < NUM_PAT; k++) begin
            pat_eff[k] = variant_sel ? {1'b0, pat_raw[k][PAT_W-1:1]} : pat_raw[k];
        end
    end

    assign chr_addr = {pat_eff[ppu_addr[12:10]], ppu_addr[PAT_OFS_W-1:0]};

    always_comb begin
        case (mirror)
            MIR_VERT:   nt_page = ppu_addr[10];
            MIR_HORZ:   nt_page = ppu_addr[11];
            MIR_ONE_LO: nt_page = 1'b0;
            default:    nt_page = 1'b1;
        endcase
    end

    AST_NT_ONE_LO: assert property (@(posedge clk) disable iff (rst)
        (mirror == MIR_ONE_LO) |-> !nt_page); // R6
    AST_NT_ONE_HI: assert property (@(posedge clk) disable iff (rst)
        (mirror == MIR_ONE_HI) |-> nt_page); // R6
    AST_VARIANT_TOPBIT: assert property (@(posedge clk) disable iff (rst)
        variant_sel |-> !chr_addr[CHR_AW-1]); // R11
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int PRG_BANK_W = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              variant_sel,
    input  logic [15:0]                       cpu_addr,
    input  logic [7:0]                        cpu_data,
    input  logic                              cpu_wr,
    input  logic                              rom_sel,
    input  logic [13:0]                       ppu_addr,
    output logic [PRG_BANK_W+12:0]            prg_addr,
    output logic [PAT_W+PAT_OFS_W-1:0]        chr_addr,
    output logic                              nt_page
);
    logic [PRG_BANK_W-1:0]         prg_lo;
    logic [PRG_BANK_W-1:0]         prg_hi;
    mir_mode_e                     mirror;
    logic [NUM_PAT-1:0][PAT_W-1:0] pat_raw;
    logic                          unused_bits;

    assign unused_bits = ^{cpu_data[7:PRG_BANK_W], ppu_addr[13]};

    cbm_reg_file #(.PRG_BANK_W(PRG_BANK_W)) regs_i (
        .clk         (clk),
        .rst         (rst),
        .variant_sel (variant_sel),
        .cpu_page    (cpu_addr[15:12]),
        .cpu_lo      (cpu_addr[1:0]),
        .cpu_data    (cpu_data[PRG_BANK_W-1:0]),
        .cpu_wr      (cpu_wr),
        .rom_sel     (rom_sel),
        .prg_lo      (prg_lo),
        .prg_hi      (prg_hi),
        .mirror      (mirror),
        .pat_raw     (pat_raw)
    );

    cbm_prg_map #(.PRG_BANK_W(PRG_BANK_W)) prg_i (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr[14:0]),
        .prg_lo   (prg_lo),
        .prg_hi   (prg_hi),
        .prg_addr (prg_addr)
    );

    cbm_pat_map pat_i (
        .clk         (clk),
        .rst         (rst),
        .variant_sel (variant_sel),
        .ppu_addr    (ppu_addr[12:0]),
        .pat_raw     (pat_raw),
        .mirror      (mirror),
        .chr_addr    (chr_addr),
        .nt_page     (nt_page)
    );
endmodule

// File: tb/cart_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb_top;
    localparam int PRG_BANK_W = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        variant_sel = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic        rom_sel = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic [PRG_BANK_W+12:0] prg_addr;
    logic [17:0] chr_addr;
    logic        nt_page;

    int checks = 0;
    int errors = 0;

    int m_prg0 = 0, m_prg1 = 0, m_mir = 0;
    int m_pat [8] = '{default: 0};

    always #5 clk = ~clk;

    cart_bank_mapper #(.PRG_BANK_W(PRG_BANK_W)) dut_i (
        .clk(clk), .rst(rst), .variant_sel(variant_sel),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
        .rom_sel(rom_sel), .ppu_addr(ppu_addr),
        .prg_addr(prg_addr), .chr_addr(chr_addr), .nt_page(nt_page)
    );

    task automatic model_write(input logic [15:0] a, input logic [7:0] d, input logic v);
        int s1, s0, k, dv;
        s1 = v ? int'(a[0]) : int'(a[1]);
        s0 = v ? int'(a[1]) : int'(a[0]);
        dv = int'(d);
        case (a[15:12])
            4'h8: m_prg0 = dv % 16;
            4'h9: m_mir  = dv % 4;
            4'hA: m_prg1 = dv % 16;
            4'hB, 4'hC, 4'hD, 4'hE: begin
                k = (int'(a[15:12]) - 11) * 2 + s1;
                if (s0 != 0) m_pat[k] = (m_pat[k] % 16) + (dv % 16) * 16;
                else         m_pat[k] = (m_pat[k] / 16) * 16 + (dv % 16);
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_prg0 = 0; m_prg1 = 0; m_mir = 0;
            for (int k = 0; k < 8; k++) m_pat[k] = 0;
        end else if (cpu_wr && rom_sel) begin
            model_write(cpu_addr, cpu_data, variant_sel);
        end
    end

    function automatic int exp_prg(input logic [15:0] a);
        int b;
        case (int'(a[14:13]))
            0: b = m_prg0;
            1: b = m_prg1;
            2: b = (1 << PRG_BANK_W) - 2;
            default: b = (1 << PRG_BANK_W) - 1;
        endcase
        return b * 8192 + int'(a) % 8192;
    endfunction

    function automatic int exp_chr(input logic [13:0] p, input logic v);
        int val;
        val = m_pat[int'(p[12:10])];
        if (v) val = val / 2;
        return val * 1024 + int'(p) % 1024;
    endfunction

    function automatic int exp_nt(input logic [13:0] p);
        case (m_mir)
            0: return int'(p[10]);
            1: return int'(p[11]);
            2: return 0;
            default: return 1;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input string req, input logic wr, input logic sel,
                        input logic [15:0] a, input logic [7:0] d, input logic [13:0] p);
        @(negedge clk);
        cpu_wr = wr; rom_sel = sel; cpu_addr = a; cpu_data = d; ppu_addr = p;
        #1;
        check(req, "prg_addr", int'(prg_addr), exp_prg(a));
        check(req, "chr_addr", int'(chr_addr), exp_chr(p, variant_sel));
        check(req, "nt_page",  int'(nt_page),  exp_nt(p));
    endtask

    task automatic wr(input string req, input logic [15:0] a, input logic [7:0] d);
        step(req, 1'b1, 1'b1, a, d, 14'h0000);
    endtask

    task automatic rd(input string req, input logic [15:0] a, input logic [13:0] p);
        step(req, 1'b0, 1'b0, a, 8'h00, p);
    endtask

    task automatic sweep_pat(input string req);
        for (int k = 0; k < 8; k++) rd(req, 16'hC000, 14'(k * 1024 + 'h155));
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd("R1", 16'h8123, 14'h0000);
        rd("R1", 16'hA777, 14'h1FFF);
        rd("R1", 16'h9000, 14'h2400);
        // R3: low window, upper data bits ignored
        wr("R3", 16'h8000, 8'hF5);
        rd("R3", 16'h8123, 14'h0000);
        rd("R3", 16'h9FFF, 14'h0000);
        // R4: second window
        wr("R4", 16'hA000, 8'h0C);
        rd("R4", 16'hA456, 14'h0000);
        rd("R4", 16'hBFFF, 14'h0000);
        // R5: fixed windows
        rd("R5", 16'hC000, 14'h0000);
        rd("R5", 16'hDFFF, 14'h0000);
        rd("R5", 16'hE001, 14'h0000);
        rd("R5", 16'hFFFF, 14'h0000);
        // R2: strobes must both be high
        step("R2", 1'b1, 1'b0, 16'h8000, 8'h03, 14'h0000);
        step("R2", 1'b0, 1'b1, 16'h8000, 8'h07, 14'h0000);
        step("R2", 1'b1, 1'b0, 16'hB000, 8'h0F, 14'h0000);
        rd("R2", 16'h8000, 14'h0000);
        rd("R2", 16'hC000, 14'h0000);
        // R6: mirroring modes
        for (int m = 0; m < 4; m++) begin
            wr("R6", 16'h9000, 8'(m + 8'hFC));
            rd("R6", 16'h8000, 14'h2000);
            rd("R6", 16'h8000, 14'h2400);
            rd("R6", 16'h8000, 14'h2800);
            rd("R6", 16'h8000, 14'h2C00);
        end
        // R7 / R8: load every pattern bank with distinct halves
        for (int k = 0; k < 8; k++) begin
            wr("R7", 16'(16'hB000 + (k / 2) * 16'h1000 + (k % 2) * 2), 8'(8'hA0 + (k * 3 + 1) % 16));
            wr("R8", 16'(16'hB001 + (k / 2) * 16'h1000 + (k % 2) * 2), 8'(8'h50 + (15 - k)));
        end
        sweep_pat("R7");
        // R8: rewrite one half only
        wr("R8", 16'hC002, 8'h09);
        rd("R8", 16'hC000, 14'h0C00);
        wr("R8", 16'hE003, 8'h02);
        rd("R8", 16'hC000, 14'h1C3F);
        // R9: aliasing within the 4 KB page
        wr("R9", 16'h8FF0, 8'h09);
        wr("R9", 16'hDABD, 8'h06);
        wr("R9", 16'hA7FE, 8'h03);
        rd("R9", 16'h8010, 14'h1000);
        rd("R9", 16'hA010, 14'h1000);
        // R12: top page is inert
        wr("R12", 16'hF000, 8'hFF);
        wr("R12", 16'hF003, 8'hFF);
        wr("R12", 16'hF9A2, 8'h77);
        rd("R12", 16'h8000, 14'h0000);
        rd("R12", 16'hA000, 14'h0000);
        sweep_pat("R12");
        // R10 / R11: alternate wiring
        variant_sel = 1'b1;
        sweep_pat("R11");
        wr("R10", 16'hB001, 8'h0A);
        wr("R10", 16'hB002, 8'h05);
        wr("R10", 16'hC003, 8'h0F);
        wr("R10", 16'hE001, 8'h01);
        sweep_pat("R10");
        wr("R11", 16'hD000, 8'h0F);
        wr("R11", 16'hD002, 8'h0F);
        sweep_pat("R11");
        variant_sel = 1'b0;
        sweep_pat("R11");
        // R1: reset after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd("R1", 16'h8000, 14'h2C00);
        rd("R1", 16'hA000, 14'h0800);
        sweep_pat("R1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule